// File: doc/BRIEF.md
# BER Bit and Error Counter

This block is the counting back end of a bit error rate tester. It runs in the receive clock domain and keeps two running counts. One counts receive clock cycles in which a bit is accepted. The other counts received bits that an upstream comparator has flagged as wrong. Both counts freeze while the upstream pattern detector reports that it has lost lock. The bit count also pauses while a receive-disable input is high.

A latch event copies both running counts into holding registers in one step and clears the running counts. A latch event is a rising edge on an external load pin, which is asynchronous and is synchronised internally, or a rising edge on a control bit that is already in the receive clock domain. A processor reads the held counts as bytes and forms the error ratio from them.

Each counter stops at its all-ones value instead of wrapping. An increment that is attempted at all-ones sets a sticky overflow flag for that counter, and only a latch event clears the flag. The counter width is a parameter of up to 32 bits. The default is 32. Narrower counts read back zero-extended to 32 bits.

Top module: `ber_count_core`

## Requirements
- R1: While `rst` is high at a clock edge, both running counts, both held counts and both overflow flags become zero, so every read address returns 0x00.
- R2: The bit count rises by one on each clock edge where `sync_ok` is high and `rx_dis` is low. It keeps its value on any edge where `rx_dis` is high.
- R3: While `sync_ok` is low, neither running count changes, except when a latch event clears it.
- R4: The error count rises by one on each clock edge where `sync_ok` and `err_strobe` are both high. The state of `rx_dis` has no effect on it.
- R5: A rising edge on `load_ctl` is sampled at the next clock edge. That edge latches both counts, including that edge's own increment, into the holding registers and restarts both running counts at zero.
- R6: `load_pin` passes through a two-flop synchroniser. A rise first sampled at clock edge n latches at edge n+2. Holding the pin high causes no further latch events.
- R7: When the pin path and the control path present their edges at the same clock edge, exactly one latch event occurs.
- R8: A running count that reaches all-ones stays at all-ones until a latch event and never wraps to zero.
- R9: An increment attempted while a count is at all-ones sets that counter's flag (`bit_ovf` or `err_ovf`). The flag stays set until the next latch event, which clears it.
- R10: `rd_data` is a combinational function of `rd_addr`. Addresses 0x8 to 0xB return the held bit count and 0xC to 0xF return the held error count, most significant byte first. Addresses 0x0 to 0x7 return 0x00. The held values change only at a latch event or a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive bit clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_dis | input | 1 | High pauses the bit count |
| sync_ok | input | 1 | High while the upstream detector is locked |
| err_strobe | input | 1 | High for a received bit in error |
| load_pin | input | 1 | Asynchronous load request; its rising edge latches |
| load_ctl | input | 1 | Load request from a control register; its rising edge latches |
| rd_addr | input | 4 | Byte read address |
| rd_data | output | 8 | Byte of the selected held count |
| bit_ovf | output | 1 | Sticky bit-count overflow flag |
| err_ovf | output | 1 | Sticky error-count overflow flag |

## Verification
The bound checker enforces the following rules on every clock:
- a count never changes while lock is lost or, for the bit count, while `rx_dis` is high;
- a latch event always leaves both running counts at zero;
- a count at all-ones never wraps;
- a flag that has been raised stays up until a latch event;
- the held values change only at a latch event;
- the low address range reads zero.

Some behaviour shows only in the bench scenarios: the exact clock edge at which a pin edge takes effect, the inclusion of the increment from the latch edge itself, the single event produced when both edges coincide, and the exact byte values that are read back.

// File: rtl/ber_cnt_pkg.sv
package ber_cnt_pkg;
  localparam int RD_ADDR_W     = 4;
  localparam int RD_W          = 8;
  localparam int BYTES_PER_CNT = 4;
  localparam int VIEW_W        = BYTES_PER_CNT * RD_W;
  localparam int NUM_CNT       = 2;

  typedef enum logic [0:0] {
    CNT_BITS = 1'b0,
    CNT_ERRS = 1'b1
  } cnt_sel_e;
endpackage

// File: rtl/ber_load_edge.sv
module ber_load_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load_pin,
  input  logic load_ctl,
  output logic latch_evt
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] pin_chain;
  logic             ctl_q;
  logic             pin_rise;
  logic             ctl_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_chain <= '0;
      ctl_q     <= 1'b0;
    end else begin
      pin_chain <= {pin_chain[CHAIN-2:0], load_pin};
      ctl_q     <= load_ctl;
    end
  end

  assign pin_rise  = pin_chain[SYNC_STAGES-1] & ~pin_chain[SYNC_STAGES];
  assign ctl_rise  = load_ctl & ~ctl_q;
  assign latch_evt = pin_rise | ctl_rise;
endmodule

// File: rtl/ber_sat_counter.sv
module ber_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] run,
  output logic [W-1:0] hold,
  output logic         ovf
);
  localparam logic [W-1:0] TOP = '1;

  logic         at_top;
  logic [W-1:0] nxt;

  assign at_top = (run == TOP);
  assign nxt    = (inc && !at_top) ? run + W'(1) : run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= '0;
      hold <= '0;
      ovf  <= 1'b0;
    end else if (clr) begin
      hold <= nxt;
      run  <= '0;
      ovf  <= 1'b0;
    end else begin
      run <= nxt;
      if (inc && at_top) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/ber_byte_mux.sv
module ber_byte_mux
  import ber_cnt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [RD_ADDR_W-1:0] rd_addr,
  input  logic [W-1:0]         bit_hold,
  input  logic [W-1:0]         err_hold,
  output logic [RD_W-1:0]      rd_data
);
  cnt_sel_e          sel;
  logic [VIEW_W-1:0] view;
  logic [1:0]        lane;

  assign sel  = cnt_sel_e'(rd_addr[2]);
  assign lane = rd_addr[1:0];

  always_comb begin
    view = (sel == CNT_ERRS) ? VIEW_W'(err_hold) : VIEW_W'(bit_hold);
    if (!rd_addr[3]) begin
      rd_data = '0;
    end else begin
      case (lane)
        2'd0:    rd_data = view[31:24];
        2'd1:    rd_data = view[23:16];
        2'd2:    rd_data = view[15:8];
        default: rd_data = view[7:0];
      endcase
    end
  end
endmodule

// File: rtl/ber_count_core.sv
module ber_count_core
  import ber_cnt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_dis,
  input  logic                 sync_ok,
  input  logic                 err_strobe,
  input  logic                 load_pin,
  input  logic                 load_ctl,
  input  logic [RD_ADDR_W-1:0] rd_addr,
  output logic [RD_W-1:0]      rd_data,
  output logic                 bit_ovf,
  output logic                 err_ovf
);
  logic               latch_evt;
  logic [NUM_CNT-1:0] inc_vec;
  logic [NUM_CNT-1:0] ovf_vec;
  logic [CNT_W-1:0]   run_arr  [NUM_CNT];
  logic [CNT_W-1:0]   hold_arr [NUM_CNT];
  logic [CNT_W-1:0]   bit_run, err_run, bit_hold, err_hold;

  ber_load_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rst       (rst),
    .load_pin  (load_pin),
    .load_ctl  (load_ctl),
    .latch_evt (latch_evt)
  );

  assign inc_vec[int'(CNT_BITS)] = sync_ok & ~rx_dis;
  assign inc_vec[int'(CNT_ERRS)] = sync_ok & err_strobe;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    ber_sat_counter #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .inc  (inc_vec[i]),
      .clr  (latch_evt),
      .run  (run_arr[i]),
      .hold (hold_arr[i]),
      .ovf  (ovf_vec[i])
    );
  end

  assign bit_run  = run_arr[int'(CNT_BITS)];
  assign err_run  = run_arr[int'(CNT_ERRS)];
  assign bit_hold = hold_arr[int'(CNT_BITS)];
  assign err_hold = hold_arr[int'(CNT_ERRS)];
  assign bit_ovf  = ovf_vec[int'(CNT_BITS)];
  assign err_ovf  = ovf_vec[int'(CNT_ERRS)];

  ber_byte_mux #(.W(CNT_W)) u_mux (
    .rd_addr  (rd_addr),
    .bit_hold (bit_hold),
    .err_hold (err_hold),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/ber_count_chk.sv
module ber_count_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_dis,
  input logic             sync_ok,
  input logic             latch_evt,
  input logic [CNT_W-1:0] bit_run,
  input logic [CNT_W-1:0] err_run,
  input logic [CNT_W-1:0] bit_hold,
  input logic [CNT_W-1:0] err_hold,
  input logic             bit_ovf,
  input logic             err_ovf,
  input logic [3:0]       rd_addr,
  input logic [7:0]       rd_data
);
  localparam logic [CNT_W-1:0] TOP = '1;

  a_r2_dis_pauses: assert property (@(posedge clk) disable iff (rst)
    rx_dis && !latch_evt |=> $stable(bit_run));

  a_r3_no_sync_hold: assert property (@(posedge clk) disable iff (rst)
    !sync_ok && !latch_evt |=> $stable(bit_run) && $stable(err_run));

  a_r5_latch_clears: assert property (@(posedge clk) disable iff (rst)
    latch_evt |=> (bit_run == '0) && (err_run == '0));

  a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (bit_run == TOP) && !latch_evt |=> (bit_run == TOP));

  a_r8_no_wrap_err: assert property (@(posedge clk) disable iff (rst)
    (err_run == TOP) && !latch_evt |=> (err_run == TOP));

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    bit_ovf && !latch_evt |=> bit_ovf);

  a_r9_flag_sticky_err: assert property (@(posedge clk) disable iff (rst)
    err_ovf && !latch_evt |=> err_ovf);

  a_r9_flag_cleared: assert property (@(posedge clk) disable iff (rst)
    latch_evt |=> !bit_ovf && !err_ovf);

  a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
    !latch_evt |=> $stable(bit_hold) && $stable(err_hold));

  always_comb begin
    if (!rst && !rd_addr[3]) begin
      a_r10_low_range_zero: assert (rd_data == 8'h00);
    end
  end
endmodule

bind ber_count_core ber_count_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_dis    (rx_dis),
  .sync_ok   (sync_ok),
  .latch_evt (latch_evt),
  .bit_run   (bit_run),
  .err_run   (err_run),
  .bit_hold  (bit_hold),
  .err_hold  (err_hold),
  .bit_ovf   (bit_ovf),
  .err_ovf   (err_ovf),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data)
);

// File: tb/tb_ber_count_core.sv
module tb_ber_count_core;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 10;
  localparam longint MAXV   = (longint'(1) << W) - 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_dis = 1'b0, sync_ok = 1'b0, err_strobe = 1'b0;
  logic       load_pin = 1'b0, load_ctl = 1'b0;
  logic [3:0] rd_addr = 4'd0;
  logic [7:0] rd_data;
  logic       bit_ovf, err_ovf;

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R1";

  ber_count_core #(.CNT_W(W)) dut (
    .clk(clk), .rst(rst), .rx_dis(rx_dis), .sync_ok(sync_ok),
    .err_strobe(err_strobe), .load_pin(load_pin), .load_ctl(load_ctl),
    .rd_addr(rd_addr), .rd_data(rd_data), .bit_ovf(bit_ovf), .err_ovf(err_ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  longint m_br, m_er, m_bh, m_eh;
  bit     m_bo, m_eo;
  bit     m_p1, m_p2, m_p3, m_c;

  always @(posedge clk) begin
    if (rst) begin
      m_br = 0; m_er = 0; m_bh = 0; m_eh = 0; m_bo = 0; m_eo = 0;
      m_p1 = 0; m_p2 = 0; m_p3 = 0; m_c = 0;
    end else begin
      bit ib, ie, ev;
      longint nb, ne;
      ib = sync_ok && !rx_dis;
      ie = sync_ok && err_strobe;
      ev = (m_p2 && !m_p3) || (load_ctl && !m_c);
      nb = (ib && m_br != MAXV) ? m_br + 1 : m_br;
      ne = (ie && m_er != MAXV) ? m_er + 1 : m_er;
      if (ev) begin
        m_bh = nb; m_eh = ne; m_br = 0; m_er = 0; m_bo = 0; m_eo = 0;
      end else begin
        if (ib && m_br == MAXV) m_bo = 1;
        if (ie && m_er == MAXV) m_eo = 1;
        m_br = nb; m_er = ne;
      end
      m_p3 = m_p2; m_p2 = m_p1; m_p1 = load_pin; m_c = load_ctl;
    end
  end

  function automatic int model_read(input logic [3:0] a);
    longint v;
    if (!a[3]) return 0;
    v = a[2] ? m_eh : m_bh;
    return int'((v >> (8 * (3 - int'(a[1:0])))) & 255);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check({cur_req, " rd_data"}, rd_data, model_read(rd_addr));
      check("R9 bit_ovf", bit_ovf, m_bo);
      check("R9 err_ovf", err_ovf, m_eo);
    end
  end

  task automatic step(input bit s, input bit d, input bit e, input bit p, input bit c);
    @(negedge clk);
    #1;
    sync_ok = s; rx_dis = d; err_strobe = e; load_pin = p; load_ctl = c;
    rd_addr = rd_addr + 4'd1;
  endtask

  task automatic read_val(input logic [3:0] base, output longint v);
    v = 0;
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      #1;
      sync_ok = 0; rx_dis = 0; err_strobe = 0;
      rd_addr = base + 4'(b);
      #2;
      v = (v << 8) | longint'(rd_data);
    end
  endtask

  task automatic expect_hold(input string req, input longint eb, input longint ee);
    longint v;
    read_val(4'h8, v);
    check({req, " held bit count"}, v, eb);
    read_val(4'hC, v);
    check({req, " held error count"}, v, ee);
  endtask

  initial begin
    longint v;
    repeat (3) @(negedge clk);
    #1 rst = 0;
    // R1: reset state, all addresses read zero
    for (int a = 0; a < 16; a++) begin
      @(negedge clk); #1 rd_addr = 4'(a); #2;
      check("R1 reset read", rd_data, 0);
    end
    check("R1 bit_ovf after reset", bit_ovf, 0);
    check("R1 err_ovf after reset", err_ovf, 0);

    // R2/R4/R5: 20 counted bits, errors on every third
    cur_req = "R2";
    for (int i = 0; i < 20; i++) step(1, 0, (i % 3) == 0, 0, 0);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);
    expect_hold("R5", 20, 7);

    // R2 pause via rx_dis, R4 errors counted during pause, R3 lock lost
    cur_req = "R3";
    for (int i = 0; i < 10; i++) step(1, 1, 1, 0, 0);
    for (int i = 0; i < 5; i++)  step(1, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++)  step(0, 0, 1, 0, 0);
    step(1, 0, 1, 0, 1);            // latch edge includes its own increment
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0);
    // R6: pin rise, latch two edges after first sample
    cur_req = "R6";
    step(1, 0, 0, 1, 0);
    step(1, 0, 0, 1, 0);
    step(1, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    expect_hold("R6", 7, 0);        // pin still high: no repeat event
    // earlier latch with increments from R4/R2 mix
    check("R4 error count ignored rx_dis (via model)", n_bad, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);

    // R7: pin edge and control edge coincide
    cur_req = "R7";
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 1, 0);
    step(1, 0, 0, 1, 0);
    step(1, 0, 0, 1, 1);
    step(1, 0, 0, 1, 1);
    expect_hold("R7", 5, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);

    // R8/R9: saturation and sticky flags
    cur_req = "R8";
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);
    for (int i = 0; i < 1030; i++) step(1, 0, 1, 0, 0);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0);
    #2;
    check("R9 bit_ovf sticky", bit_ovf, 1);
    check("R9 err_ovf sticky", err_ovf, 1);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);
    expect_hold("R8", MAXV, MAXV);
    check("R9 bit_ovf cleared by latch", bit_ovf, 0);
    check("R9 err_ovf cleared by latch", err_ovf, 0);

    // R10: byte order and low range zero while held counts are nonzero
    cur_req = "R10";
    @(negedge clk); #1 rd_addr = 4'hA; #2;
    check("R10 byte 0xA", rd_data, 8'h03);
    @(negedge clk); #1 rd_addr = 4'hB; #2;
    check("R10 byte 0xB", rd_data, 8'hFF);
    @(negedge clk); #1 rd_addr = 4'h8; #2;
    check("R10 msb byte 0x8", rd_data, 0);
    for (int a = 0; a < 8; a++) begin
      @(negedge clk); #1 rd_addr = 4'(a); #2;
      check("R10 low range", rd_data, 0);
    end
    read_val(4'h8, v);
    check("R10 hold stable without latch", v, MAXV);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule